// File: doc/BRIEF.md
# Configuration Cycle Router for a Bus-to-Bus Bridge

This block is the routing decision of a bridge that joins an upstream (primary) bus to a downstream (secondary) bus. It watches configuration requests that arrive on the primary side. For each request it decides whether the bridge takes it as an access to its own registers, drops it, or sends it downstream. A request it sends downstream either stays a type 1 request or becomes a type 0 request aimed at one slot.

The bridge holds three bus numbers. The primary number is the bus the bridge sits on. The secondary number is the bus directly behind it. The subordinate number is the highest bus number reachable through it. Software programs all three through type 0 accesses that select the bridge itself.

For a type 1 request, the target bus number is compared with the secondary and subordinate numbers. The result picks one of three outcomes: drop, convert, or pass unchanged. A converted request carries a one-hot slot select in its upper address bits. Every decision is registered, and the results appear on the outputs one clock after the request.

Top module: `cfg_route_bridge`

## Requirements
- R1: While `rst_n` is low and after it rises, the primary, secondary and subordinate numbers are 0, and `claim`, `dn_valid`, `dn_write`, `dn_no_target`, `dn_addr` and `rsp_rdata` are all 0.
- R2: A type 0 request (`req_kind`=0) with `self_select`=1 and `req_reg`=`BUSNUM_IDX` (default 6) is claimed. A write loads primary from `req_wdata[7:0]`, secondary from `[15:8]` and subordinate from `[23:16]`. A read returns {subordinate, secondary, primary} in the same bit positions on `rsp_rdata`.
- R3: A type 0 request with `self_select`=0 is not claimed and not forwarded. A type 0 self access to any other register index reads 0 and does not change the bus numbers.
- R4: A type 1 request (`req_kind`=1) whose bus number is below the secondary number or above the subordinate number is not claimed and not forwarded.
- R5: A type 1 request whose bus number equals the secondary number, while subordinate ≥ secondary, is claimed and forwarded as type 0. The downstream address has bits 1:0 = 00, bits 7:2 = register, bits 10:8 = function, and bit 11+device set as the only select bit in 31:11.
- R6: A type 1 request whose bus number is above the secondary number and no higher than the subordinate number is claimed and forwarded unchanged. The downstream address has bits 1:0 = 01, bits 7:2 = register, bits 10:8 = function, bits 15:11 = device, bits 23:16 = bus, and bits 31:24 = 0.
- R7: With subordinate = 0xFF, every bus number above the secondary number is forwarded as type 1, up to and including 0xFF.
- R8: A converted request whose device number is 21 or more has every bit of 31:11 clear and raises `dn_no_target`, which marks that it ends as a master abort. `dn_no_target` is 0 for every other result.
- R9: `dn_write` equals the request's `req_write` on every forwarded request, and is 0 when nothing is forwarded.
- R10: When subordinate < secondary, no type 1 request is claimed, including one whose bus number equals the secondary number.
- R11: Results appear one clock after the request cycle. A cycle with `req_valid`=0 gives `claim`=0, `dn_valid`=0 and `rsp_rdata`=0 one clock later. A register write takes effect for the request in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A configuration request is present this cycle |
| req_kind | input | 1 | 0 = type 0 request, 1 = type 1 request |
| req_bus | input | 8 | Target bus number (type 1 only) |
| req_dev | input | 5 | Device (slot) number |
| req_func | input | 3 | Function number |
| req_reg | input | 6 | Register (dword) index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 24 | Write data for the bridge's own bus-number register |
| self_select | input | 1 | The bridge itself is selected by a type 0 request |
| claim | output | 1 | The bridge accepted the previous request |
| dn_valid | output | 1 | A request is issued on the secondary side |
| dn_addr | output | 32 | Secondary-side address (type 0 or type 1 layout) |
| dn_write | output | 1 | Direction of the forwarded request |
| dn_no_target | output | 1 | Converted request selects no slot |
| rsp_rdata | output | 24 | Read data of a local register read |

## Verification
The bench targets the edges of the bus-number window. It drives the secondary number itself, the subordinate number itself, one below the secondary number, and one above the subordinate number. An off-by-one comparison would wrongly drop or wrongly forward one of these. It also programs an inverted window, where subordinate is below secondary. A design that tests only for equality with the secondary number would claim and convert there. Converted requests cover device 0, device 20 and devices 21 and 31, so a shifter that wraps or saturates would set a stray select bit. A write followed at once by a routed request confirms that the new numbers are used on the very next cycle.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

   // Routing outcome for one primary-side request
   typedef enum logic [1:0] {
      RT_DROP  = 2'd0,
      RT_LOCAL = 2'd1,
      RT_TYPE0 = 2'd2,
      RT_TYPE1 = 2'd3
   } route_e;

   // Low two address bits that tag the downstream format
   localparam logic [1:0] KIND0_TAG = 2'b00;
   localparam logic [1:0] KIND1_TAG = 2'b01;

   // Number of programmable bus-number fields
   localparam int unsigned NUM_FIELDS = 3;

endpackage

// File: rtl/cfgr_busnum_regs.sv
module cfgr_busnum_regs #(
   parameter int unsigned BUS_W = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [cfgr_pkg::NUM_FIELDS*BUS_W-1:0] wr_data,
   output logic [BUS_W-1:0]               pri_o,
   output logic [BUS_W-1:0]               sec_o,
   output logic [BUS_W-1:0]               sub_o
);
   import cfgr_pkg::*;

   logic [BUS_W-1:0] field_q [NUM_FIELDS];

   // One register per field, lane i of the write word
   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            field_q[i] <= '0;
         end else if (wr_en) begin
            field_q[i] <= wr_data[i*BUS_W +: BUS_W];
         end
      end
   end

   assign pri_o = field_q[0];
   assign sec_o = field_q[1];
   assign sub_o = field_q[2];

endmodule

// File: rtl/cfgr_route_decide.sv
module cfgr_route_decide #(
   parameter int unsigned BUS_W = 8
) (
   input  logic               kind1,
   input  logic               self_sel,
   input  logic [BUS_W-1:0]   bus,
   input  logic [BUS_W-1:0]   sec,
   input  logic [BUS_W-1:0]   sub,
   output cfgr_pkg::route_e   route
);
   import cfgr_pkg::*;

   logic window_ok;
   logic hit_sec;
   logic above_sec;
   logic within_sub;

   assign window_ok  = (sub >= sec);
   assign hit_sec    = (bus == sec);
   assign above_sec  = (bus >  sec);
   assign within_sub = (bus <= sub);

   always_comb begin
      route = RT_DROP;
      if (!kind1) begin
         if (self_sel) route = RT_LOCAL;
      end else if (hit_sec && window_ok) begin
         route = RT_TYPE0;
      end else if (above_sec && within_sub) begin
         route = RT_TYPE1;
      end
   end

endmodule

// File: rtl/cfgr_addr_fmt.sv
module cfgr_addr_fmt #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned DEV_W  = 5,
   parameter int unsigned FUNC_W = 3,
   parameter int unsigned REG_W  = 6
) (
   input  cfgr_pkg::route_e   route,
   input  logic [BUS_W-1:0]   bus,
   input  logic [DEV_W-1:0]   dev,
   input  logic [FUNC_W-1:0]  func,
   input  logic [REG_W-1:0]   regn,
   output logic [ADDR_W-1:0]  addr,
   output logic               no_target
);
   import cfgr_pkg::*;

   localparam int unsigned SEL_LSB = 2 + REG_W + FUNC_W;
   localparam int unsigned NSEL    = ADDR_W - SEL_LSB;
   localparam int unsigned T1_W    = 2 + REG_W + FUNC_W + DEV_W + BUS_W;

   logic [NSEL-1:0]   slot_sel;
   logic [ADDR_W-1:0] addr_t0;
   logic [ADDR_W-1:0] addr_t1;

   // One comparator per select line; out-of-range devices match none
   for (genvar s = 0; s < NSEL; s++) begin : g_slot
      assign slot_sel[s] = (dev == DEV_W'(s));
   end

   assign addr_t0   = {slot_sel, func, regn, KIND0_TAG};
   assign addr_t1   = ADDR_W'({bus, dev, func, regn, KIND1_TAG});
   assign no_target = (route == RT_TYPE0) && (slot_sel == '0);

   always_comb begin
      unique case (route)
         RT_TYPE0: addr = addr_t0;
         RT_TYPE1: addr = addr_t1;
         default:  addr = '0;
      endcase
   end

   if (T1_W > ADDR_W) begin : g_bad_t1
      $error("address too narrow for type 1 layout");
   end

endmodule

// File: rtl/cfg_route_bridge.sv
module cfg_route_bridge #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned BUS_W      = 8,
   parameter int unsigned DEV_W      = 5,
   parameter int unsigned FUNC_W     = 3,
   parameter int unsigned REG_W      = 6,
   parameter int unsigned BUSNUM_IDX = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic                         req_kind,
   input  logic [BUS_W-1:0]             req_bus,
   input  logic [DEV_W-1:0]             req_dev,
   input  logic [FUNC_W-1:0]            req_func,
   input  logic [REG_W-1:0]             req_reg,
   input  logic                         req_write,
   input  logic [3*BUS_W-1:0]           req_wdata,
   input  logic                         self_select,
   output logic                         claim,
   output logic                         dn_valid,
   output logic [ADDR_W-1:0]            dn_addr,
   output logic                         dn_write,
   output logic                         dn_no_target,
   output logic [3*BUS_W-1:0]           rsp_rdata
);
   import cfgr_pkg::*;

   localparam int unsigned SEL_LSB = 2 + REG_W + FUNC_W;
   localparam int unsigned DATA_W  = NUM_FIELDS * BUS_W;

   // Elaboration-time parameter checks
   if (SEL_LSB >= ADDR_W) begin : g_bad_sel
      $error("no room for slot select bits");
   end
   if (BUSNUM_IDX >= (1 << REG_W)) begin : g_bad_idx
      $error("bus-number register index out of range");
   end
   if (DATA_W != 3 * BUS_W) begin : g_bad_data
      $error("field count does not match data width");
   end

   logic [BUS_W-1:0]  pri_n, sec_n, sub_n;
   route_e            route;
   logic [ADDR_W-1:0] fmt_addr;
   logic              fmt_no_target;
   logic              is_local, is_fwd, hits_busnum, local_wr;

   assign is_local    = req_valid && (route == RT_LOCAL);
   assign is_fwd      = req_valid && ((route == RT_TYPE0) || (route == RT_TYPE1));
   assign hits_busnum = (req_reg == REG_W'(BUSNUM_IDX));
   assign local_wr    = is_local && req_write && hits_busnum;

   cfgr_busnum_regs #(.BUS_W(BUS_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (local_wr),
      .wr_data (req_wdata),
      .pri_o   (pri_n),
      .sec_o   (sec_n),
      .sub_o   (sub_n)
   );

   cfgr_route_decide #(.BUS_W(BUS_W)) u_decide (
      .kind1    (req_kind),
      .self_sel (self_select),
      .bus      (req_bus),
      .sec      (sec_n),
      .sub      (sub_n),
      .route    (route)
   );

   cfgr_addr_fmt #(
      .ADDR_W (ADDR_W),
      .BUS_W  (BUS_W),
      .DEV_W  (DEV_W),
      .FUNC_W (FUNC_W),
      .REG_W  (REG_W)
   ) u_fmt (
      .route     (route),
      .bus       (req_bus),
      .dev       (req_dev),
      .func      (req_func),
      .regn      (req_reg),
      .addr      (fmt_addr),
      .no_target (fmt_no_target)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         claim        <= 1'b0;
         dn_valid     <= 1'b0;
         dn_addr      <= '0;
         dn_write     <= 1'b0;
         dn_no_target <= 1'b0;
         rsp_rdata    <= '0;
      end else begin
         claim        <= req_valid && (route != RT_DROP);
         dn_valid     <= is_fwd;
         dn_addr      <= is_fwd ? fmt_addr : '0;
         dn_write     <= is_fwd && req_write;
         dn_no_target <= req_valid && fmt_no_target;
         rsp_rdata    <= (is_local && !req_write && hits_busnum)
                         ? {sub_n, sec_n, pri_n} : '0;
      end
   end

endmodule

// File: rtl/cfgr_checker.sv
module cfgr_checker #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned BUS_W   = 8,
   parameter int unsigned SEL_LSB = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_kind,
   input logic [BUS_W-1:0]  req_bus,
   input logic              req_write,
   input logic [BUS_W-1:0]  sec_num,
   input logic [BUS_W-1:0]  sub_num,
   input logic              claim,
   input logic              dn_valid,
   input logic [ADDR_W-1:0] dn_addr,
   input logic              dn_write,
   input logic              dn_no_target
);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!claim && !dn_valid && !dn_no_target));

   assert_drop_outside_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind && ((req_bus < sec_num) || (req_bus > sub_num)))
      |=> (!claim && !dn_valid));

   assert_convert_sec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind && (req_bus == sec_num) && (sub_num >= sec_num))
      |=> (dn_valid && (dn_addr[1:0] == 2'b00)));

   assert_onehot_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && (dn_addr[1:0] == 2'b00)) |-> $onehot0(dn_addr[ADDR_W-1:SEL_LSB]));

   assert_pass_bus_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind && (req_bus > sec_num) && (req_bus <= sub_num))
      |=> (dn_valid && (dn_addr[1:0] == 2'b01) && (dn_addr[23:16] == $past(req_bus))));

   assert_no_target_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dn_no_target |-> (dn_valid && (dn_addr[ADDR_W-1:SEL_LSB] == '0)));

   assert_write_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind) |=> (!dn_valid || (dn_write == $past(req_write))));

   assert_fwd_claimed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> claim);

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!claim && !dn_valid));

endmodule

bind cfg_route_bridge cfgr_checker #(
   .ADDR_W  (ADDR_W),
   .BUS_W   (BUS_W),
   .SEL_LSB (SEL_LSB)
) u_cfgr_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_kind     (req_kind),
   .req_bus      (req_bus),
   .req_write    (req_write),
   .sec_num      (sec_n),
   .sub_num      (sub_n),
   .claim        (claim),
   .dn_valid     (dn_valid),
   .dn_addr      (dn_addr),
   .dn_write     (dn_write),
   .dn_no_target (dn_no_target)
);

// File: tb/test_cfg_route_bridge.sv
`timescale 1ns/1ps
module test_cfg_route_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_kind = 1'b0, req_write = 1'b0, self_select = 1'b0;
   logic [7:0]  req_bus = '0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_func = '0;
   logic [5:0]  req_reg = '0;
   logic [23:0] req_wdata = '0;
   logic        claim, dn_valid, dn_write, dn_no_target;
   logic [31:0] dn_addr;
   logic [23:0] rsp_rdata;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic        cl, dv, dw, nt;
      logic [31:0] addr;
      logic [23:0] rd;
      string       tag;
   } exp_t;

   exp_t q[$];
   logic [7:0] m_pri = '0, m_sec = '0, m_sub = '0;

   always #10 clk = ~clk;

   cfg_route_bridge i_cfg_route_bridge (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func), .req_reg(req_reg),
      .req_write(req_write), .req_wdata(req_wdata), .self_select(self_select),
      .claim(claim), .dn_valid(dn_valid), .dn_addr(dn_addr), .dn_write(dn_write),
      .dn_no_target(dn_no_target), .rsp_rdata(rsp_rdata)
   );

   task automatic drive(input bit v, input bit kind, input bit sel, input bit wr,
                        input logic [7:0] bus, input logic [4:0] dev,
                        input logic [2:0] fn, input logic [5:0] rg,
                        input logic [23:0] wd, input string tag);
      exp_t e;
      @(negedge clk);
      req_valid = v; req_kind = kind; self_select = sel; req_write = wr;
      req_bus = bus; req_dev = dev; req_func = fn; req_reg = rg; req_wdata = wd;
      e.cl = 0; e.dv = 0; e.dw = 0; e.nt = 0; e.addr = '0; e.rd = '0; e.tag = tag;
      if (v) begin
         if (!kind) begin
            if (sel) begin
               e.cl = 1;
               if (rg == 6'd6) begin
                  if (wr) begin
                     m_pri = wd[7:0]; m_sec = wd[15:8]; m_sub = wd[23:16];
                  end else begin
                     e.rd = {m_sub, m_sec, m_pri};
                  end
               end
            end
         end else if (bus == m_sec && m_sub >= m_sec) begin
            e.cl = 1; e.dv = 1; e.dw = wr;
            e.addr = {24'h0, fn, rg, 2'b00};
            if (dev < 5'd21) e.addr = e.addr | (32'h1 << (11 + dev));
            else e.nt = 1;
         end else if (bus > m_sec && bus <= m_sub) begin
            e.cl = 1; e.dv = 1; e.dw = wr;
            e.addr = {8'h00, bus, dev, fn, rg, 2'b01};
         end
      end
      q.push_back(e);
   endtask

   task automatic t1(input logic [7:0] bus, input logic [4:0] dev, input bit wr, input string tag);
      drive(1, 1, 0, wr, bus, dev, 3'd5, 6'h2A, 24'h0, tag);
   endtask

   task automatic setnum(input logic [7:0] p, input logic [7:0] s, input logic [7:0] u, input string tag);
      drive(1, 0, 1, 1, 8'h0, 5'd0, 3'd0, 6'd6, {u, s, p}, tag);
   endtask

   task automatic rdnum(input string tag);
      drive(1, 0, 1, 0, 8'h0, 5'd0, 3'd0, 6'd6, 24'h0, tag);
   endtask

   // Monitor: compare each expected item one edge after it was driven
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (claim !== e.cl || dn_valid !== e.dv || dn_write !== e.dw ||
                dn_no_target !== e.nt || dn_addr !== e.addr || rsp_rdata !== e.rd) begin
               errors++;
               $display("FAIL %s: actual cl=%b dv=%b dw=%b nt=%b addr=%h rd=%h expected cl=%b dv=%b dw=%b nt=%b addr=%h rd=%h",
                        e.tag, claim, dn_valid, dn_write, dn_no_target, dn_addr, rsp_rdata,
                        e.cl, e.dv, e.dw, e.nt, e.addr, e.rd);
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (claim !== 0 || dn_valid !== 0 || dn_addr !== 0 || dn_write !== 0 ||
          dn_no_target !== 0 || rsp_rdata !== 0) begin
         errors++;
         $display("FAIL R1 reset outputs: actual cl=%b dv=%b addr=%h expected all zero",
                  claim, dn_valid, dn_addr);
      end
      @(negedge clk);
      rst_n = 1'b1;

      rdnum("R1 numbers zero after reset");
      t1(8'h00, 5'd3, 0, "R5 bus equals reset secondary");
      drive(0, 1, 0, 0, 8'h00, 5'd0, 3'd0, 6'd0, 24'h0, "R11 idle after request");

      setnum(8'h00, 8'h01, 8'hFF, "R2 write numbers");
      rdnum("R2 read numbers back");
      t1(8'h01, 5'd0, 0, "R5 slot 0 select bit 11");
      t1(8'h01, 5'd1, 1, "R5 R9 slot 1 select bit 12 write");
      t1(8'h01, 5'd20, 0, "R5 slot 20 select bit 31");
      t1(8'h01, 5'd21, 0, "R8 device 21 no target");
      t1(8'h01, 5'd31, 1, "R8 device 31 no target");
      t1(8'h00, 5'd2, 0, "R4 below secondary");
      t1(8'h02, 5'd4, 1, "R7 R9 pass just above secondary");
      t1(8'h80, 5'd9, 0, "R7 pass mid range");
      t1(8'hFF, 5'd31, 0, "R7 pass bus 0xFF");

      setnum(8'h02, 8'h03, 8'h05, "R2 narrow window");
      t1(8'h03, 5'd7, 1, "R11 R5 new secondary used next cycle");
      t1(8'h02, 5'd0, 0, "R4 one below secondary");
      t1(8'h04, 5'd1, 0, "R6 inside window");
      t1(8'h05, 5'd2, 1, "R6 R9 at subordinate");
      t1(8'h06, 5'd3, 0, "R4 one above subordinate");
      drive(0, 1, 0, 1, 8'h04, 5'd1, 3'd0, 6'd0, 24'h0, "R11 invalid request ignored");

      drive(1, 0, 0, 1, 8'h00, 5'd0, 3'd0, 6'd6, 24'hAAAAAA, "R3 type0 not selected");
      drive(1, 0, 1, 1, 8'h00, 5'd0, 3'd0, 6'd5, 24'h777777, "R3 write other index");
      drive(1, 0, 1, 0, 8'h00, 5'd0, 3'd0, 6'd5, 24'h0, "R3 read other index");
      rdnum("R3 numbers unchanged");

      setnum(8'h00, 8'h07, 8'h04, "R10 inverted window");
      t1(8'h07, 5'd0, 0, "R10 bus equals secondary dropped");
      t1(8'h04, 5'd0, 0, "R10 bus equals subordinate dropped");
      rdnum("R10 read inverted numbers");
      drive(0, 0, 0, 0, 8'h00, 5'd0, 3'd0, 6'd0, 24'h0, "R11 final idle");

      repeat (4) @(posedge clk);
      #2;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule